// File: doc/BRIEF.md
# Dual DAC Serial Command Controller

This block is the digital front end of a two-channel, 12-bit voltage-output converter. A host sends it 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The block runs on its own system clock. It synchronises the three link wires, detects falling edges of the serial clock, and builds each word in a shift register. When the sixteenth bit arrives, it decodes the word and executes it exactly once.

Each channel has a staging (input) register and an output (DAC) register. Only the output register drives the code sent to the converter. Commands can load the staging register, copy staging to output, or write straight through. Each can target channel A, channel B or both. A separate shutdown command class floats or wakes each channel.

The serial link has no back-pressure. The host owns the pace, and the block must accept every bit edge the host gives it. For this reason the stream interface is the plain three-wire link and not a valid/ready pair. The two output codes and the two float flags are plain level outputs. They hold their values until a command changes them.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both output codes are 0 and both float flags are 0 (channels awake). Both staging registers are also 0.
- R2: A word is 16 bits sent MSB first: a 4-bit command code (bit 15 down to bit 12), then a 12-bit data value (bit 11 down to bit 0). Data is sampled on falling edges of the serial clock while select is low.
- R3: While select is high, serial clock edges are ignored and the bit count returns to zero. A frame in which select rises before 16 falling edges runs no command.
- R4: Exactly one command runs per select-low frame, on the 16th falling edge. Extra edges in the same frame neither shift nor run a second command. The next word needs select to go high and then low again.
- R5: Codes 0000 (A), 0001 (B) and 0110 (both) write through: the data goes to the staging and output registers of the selected channels.
- R6: Codes 0010 (A), 0011 (B) and 0111 (both) load only the staging register of the selected channels. The output codes stay unchanged.
- R7: Codes 0100 (A), 0101 (B) and 1000 (both) copy the staging register to the output register of the selected channels.
- R8: Codes 1001 through 1110 change no register and no flag.
- R9: Code 1111 is shutdown control. Data bits 4..0 select the action: 00000 wakes A, 00001 floats A, 00100 wakes B, 00101 floats B. Every other value does nothing, and bits 11..5 are ignored.
- R10: A write to a floated channel updates its registers, but its float flag stays set until a wake command for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on clear) |
| ser_sel_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial bit clock from the host, sampled on its falling edge |
| ser_dat | input | 1 | Serial data, MSB first |
| code_a | output | 12 | Output register of channel A |
| code_b | output | 12 | Output register of channel B |
| float_a | output | 1 | Channel A powered down (output floating) |
| float_b | output | 1 | Channel B powered down (output floating) |

## Verification
Four properties are checked on every cycle:
- the output codes and float flags change only in the cycle after a decoded-frame strobe;
- the strobe never lasts two cycles;
- the bit count clears while select is high;
- write-through and copy commands land the expected value in the output register.

Other behaviour only the bench's scenarios can show. This covers the full command-code and shutdown-selector sweeps, MSB-first bit order, rejection of short frames and of trailing extra clocks, clocks ignored while select is high, and flags that persist across writes. The bench shows staging-register contents only through a later copy command.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
  localparam int CTRL_W = 4;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = 5;

  // bit 0 of every field is channel A, bit 1 is channel B
  typedef struct packed {
    logic [NUM_CH-1:0] ld_stage;
    logic [NUM_CH-1:0] ld_out;
    logic [NUM_CH-1:0] copy;
    logic [NUM_CH-1:0] pd_set;
    logic [NUM_CH-1:0] pd_clr;
  } dac_cmd_t;

  function automatic dac_cmd_t decode_cmd(input logic [CTRL_W-1:0] code,
                                          input logic [SEL_W-1:0]  sel);
    dac_cmd_t c;
    c = '0;
    case (code)
      4'h0: begin c.ld_stage = 2'b01; c.ld_out = 2'b01; end
      4'h1: begin c.ld_stage = 2'b10; c.ld_out = 2'b10; end
      4'h2: c.ld_stage = 2'b01;
      4'h3: c.ld_stage = 2'b10;
      4'h4: c.copy = 2'b01;
      4'h5: c.copy = 2'b10;
      4'h6: begin c.ld_stage = 2'b11; c.ld_out = 2'b11; end
      4'h7: c.ld_stage = 2'b11;
      4'h8: c.copy = 2'b11;
      4'hF: begin
        case (sel)
          5'b00000: c.pd_clr = 2'b01;
          5'b00001: c.pd_set = 2'b01;
          5'b00100: c.pd_clr = 2'b10;
          5'b00101: c.pd_set = 2'b10;
          default: ;
        endcase
      end
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sck,
  input  logic sdat,
  output logic sel_act,
  output logic sck_fall,
  output logic sdat_s
);
  logic [STAGES-1:0] sel_sh, sck_sh, dat_sh;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh   <= '1;
      sck_sh   <= '0;
      dat_sh   <= '0;
      sck_prev <= 1'b0;
    end else begin
      sel_sh   <= {sel_sh[STAGES-2:0], sel_n};
      sck_sh   <= {sck_sh[STAGES-2:0], sck};
      dat_sh   <= {dat_sh[STAGES-2:0], sdat};
      sck_prev <= sck_sh[STAGES-1];
    end
  end

  assign sel_act  = ~sel_sh[STAGES-1];
  assign sck_fall = sck_prev & ~sck_sh[STAGES-1];
  assign sdat_s   = dat_sh[STAGES-1];
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_act,
  input  logic               sck_fall,
  input  logic               sdat_s,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word,
  output logic [CNT_W-1:0]   bit_cnt
);
  logic done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_word <= '0;
      bit_cnt    <= '0;
      done       <= 1'b0;
      frame_vld  <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (!sel_act) begin
        bit_cnt <= '0;
        done    <= 1'b0;
      end else if (sck_fall && !done) begin
        frame_word <= {frame_word[FRAME_W-2:0], sdat_s};
        bit_cnt    <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
          done      <= 1'b1;
          frame_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chan_regs.sv
module chan_regs
  import dacctl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_vld,
  input  dac_cmd_t                      cmd,
  input  logic [DATA_W-1:0]             data,
  output logic [NUM_CH-1:0][DATA_W-1:0] stage_code,
  output logic [NUM_CH-1:0][DATA_W-1:0] out_code,
  output logic [NUM_CH-1:0]             floating
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_code[ch] <= '0;
        out_code[ch]   <= '0;
        floating[ch]   <= 1'b0;
      end else if (frame_vld) begin
        if (cmd.ld_stage[ch]) stage_code[ch] <= data;
        if (cmd.ld_out[ch])   out_code[ch]   <= data;
        else if (cmd.copy[ch]) out_code[ch]  <= stage_code[ch];
        if (cmd.pd_set[ch])   floating[ch]   <= 1'b1;
        else if (cmd.pd_clr[ch]) floating[ch] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacctl_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              float_a,
  output logic              float_b
);
  localparam int FRAME_W = CTRL_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic                          sel_act, sck_fall, sdat_s;
  logic                          frame_vld;
  logic [FRAME_W-1:0]            frame_word;
  logic [CNT_W-1:0]              bit_cnt;
  dac_cmd_t                      cmd;
  logic [NUM_CH-1:0][DATA_W-1:0] stage_code, out_code;
  logic [NUM_CH-1:0]             floating;

  ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_n(ser_sel_n), .sck(ser_clk), .sdat(ser_dat),
    .sel_act(sel_act), .sck_fall(sck_fall), .sdat_s(sdat_s)
  );

  frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .sck_fall(sck_fall),
    .sdat_s(sdat_s), .frame_vld(frame_vld), .frame_word(frame_word),
    .bit_cnt(bit_cnt)
  );

  assign cmd = decode_cmd(frame_word[FRAME_W-1 -: CTRL_W], frame_word[SEL_W-1:0]);

  chan_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .cmd(cmd),
    .data(frame_word[DATA_W-1:0]), .stage_code(stage_code),
    .out_code(out_code), .floating(floating)
  );

  assign code_a  = out_code[0];
  assign code_b  = out_code[1];
  assign float_a = floating[0];
  assign float_b = floating[1];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sel_act,
  input logic                     frame_vld,
  input logic [DATA_W+3:0]        frame_word,
  input logic [CNT_W-1:0]         bit_cnt,
  input logic [1:0][DATA_W-1:0]   stage_code,
  input logic [1:0][DATA_W-1:0]   out_code,
  input logic [1:0]               floating
);
  logic [3:0] code;
  assign code = frame_word[DATA_W+3 -: 4];

  // R3: count clears while select is high
  a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> bit_cnt == '0);

  // R4: a frame produces a single one-cycle strobe
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  // R5: write-through to A lands the data word
  a_r5_thru_a: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && code == 4'h0) |=> out_code[0] == $past(frame_word[DATA_W-1:0]));

  // R7: copy for B moves the staging value
  a_r7_copy_b: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && code == 4'h5) |=> out_code[1] == $past(stage_code[1]));

  // R6: output codes move only after a strobe
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(out_code));

  // R10: float flags move only after a strobe
  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(floating));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .frame_vld(frame_vld),
  .frame_word(frame_word), .bit_cnt(bit_cnt), .stage_code(stage_code),
  .out_code(out_code), .floating(floating)
);

// File: tb/dual_dac_ctrl_bench.sv
module dual_dac_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [11:0] code_a, code_b;
  logic float_a, float_b;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [11:0] m_stage [2];
  logic [11:0] m_out   [2];
  logic        m_flt   [2];

  always #4 clk = ~clk;

  dual_dac_ctrl u_dual_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .code_a(code_a), .code_b(code_b),
    .float_a(float_a), .float_b(float_b)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, int'(code_a), int'(m_out[0]));
    check(req, int'(code_b), int'(m_out[1]));
    check(req, int'(float_a), int'(m_flt[0]));
    check(req, int'(float_b), int'(m_flt[1]));
  endtask

  task automatic clk_edges_idle(input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = i[0]; waitc(4); ser_clk = 1'b1; waitc(4); ser_clk = 1'b0; waitc(4);
    end
  endtask

  // sends nbits of the word (MSB first), then extra clocks with data 1
  task automatic send(input logic [3:0] c, input logic [11:0] d,
                      input int nbits, input int extra);
    logic [15:0] w;
    w = {c, d};
    ser_sel_n = 1'b0; waitc(4);
    for (int i = 0; i < nbits + extra; i++) begin
      ser_dat = (i < nbits) ? w[15-i] : 1'b1;
      waitc(4); ser_clk = 1'b1; waitc(4); ser_clk = 1'b0; waitc(4);
    end
    ser_sel_n = 1'b1; waitc(10);
  endtask

  // reference model written from R5..R10
  task automatic model(input logic [3:0] c, input logic [11:0] d);
    bit a, b;
    a = (c == 4'h0 || c == 4'h2 || c == 4'h4 || c == 4'h6 || c == 4'h7 || c == 4'h8);
    b = (c == 4'h1 || c == 4'h3 || c == 4'h5 || c == 4'h6 || c == 4'h7 || c == 4'h8);
    for (int ch = 0; ch < 2; ch++) begin
      bit hit;
      hit = (ch == 0) ? a : b;
      if (hit) begin
        if (c == 4'h0 || c == 4'h1 || c == 4'h6) begin m_stage[ch] = d; m_out[ch] = d; end
        else if (c == 4'h2 || c == 4'h3 || c == 4'h7) m_stage[ch] = d;
        else m_out[ch] = m_stage[ch];
      end
    end
    if (c == 4'hF) begin
      if (d[4:0] == 5'd0) m_flt[0] = 1'b0;
      if (d[4:0] == 5'd1) m_flt[0] = 1'b1;
      if (d[4:0] == 5'd4) m_flt[1] = 1'b0;
      if (d[4:0] == 5'd5) m_flt[1] = 1'b1;
    end
  endtask

  task automatic do_cmd(input string req, input logic [3:0] c, input logic [11:0] d);
    send(c, d, 16, 0);
    model(c, d);
    check_all(req);
  endtask

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      m_stage[ch] = '0; m_out[ch] = '0; m_flt[ch] = 1'b0;
    end
    waitc(5); rst_n = 1'b1; waitc(5);
    check_all("R1");
    // R1: staging registers cleared too, seen through a copy to both
    do_cmd("R1", 4'h8, 12'h000);

    // R2/R5: MSB-first order with asymmetric patterns
    do_cmd("R2", 4'h0, 12'h801);
    do_cmd("R2", 4'h1, 12'h00F);

    // sweep every command code with two data patterns (R5..R8)
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 15; c++) begin
        logic [11:0] d;
        d = 12'((c * 331 + pass * 1777 + 97) & 12'hFFF);
        if (c <= 1 || c == 6)       do_cmd("R5", 4'(c), d);
        else if (c == 2 || c == 3 || c == 7) do_cmd("R6", 4'(c), d);
        else if (c == 4 || c == 5 || c == 8) do_cmd("R7", 4'(c), d);
        else                        do_cmd("R8", 4'(c), d);
      end
    end

    // R9: every selector value with noisy upper bits
    for (int s = 0; s < 32; s++) begin
      logic [11:0] d;
      d = {7'(s * 37 + 5), 5'(s)};
      do_cmd("R9", 4'hF, d);
    end

    // R10: writes to floated channels keep the flag set
    do_cmd("R10", 4'hF, 12'h001);
    do_cmd("R10", 4'hF, 12'h005);
    do_cmd("R10", 4'h6, 12'h5A5);
    do_cmd("R10", 4'h2, 12'h3C3);
    do_cmd("R10", 4'h4, 12'h000);
    do_cmd("R10", 4'hF, 12'hFE0);
    do_cmd("R10", 4'hF, 12'h004);

    // R3: short frames are dropped
    send(4'h6, 12'hABC, 15, 0); check_all("R3");
    send(4'h0, 12'h123, 7, 0);  check_all("R3");
    // R3: clocks with select high do nothing, then a clean frame works
    clk_edges_idle(20); waitc(10); check_all("R3");
    do_cmd("R3", 4'h0, 12'h6E7);

    // R4: trailing clocks after the 16th edge run nothing more
    send(4'h1, 12'h2D4, 16, 16);
    model(4'h1, 12'h2D4);
    check_all("R4");
    send(4'h6, 12'h0F0, 16, 3);
    model(4'h6, 12'h0F0);
    check_all("R4");

    finished = 1'b1;
  end

  initial begin : watchdog
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule